// File: doc/BRIEF.md
# Multi-Channel Integrate-and-Dump with Toggle-Strobe Domain Crossing

This block takes several sample streams, each arriving on its own capture clock, and sums every channel over fixed-size groups of accepted samples. The running sum is kept in the channel's own clock domain. When a group completes, the total is frozen in a holding register and a one-bit toggle flips. That toggle is the only signal that crosses into the common processing clock. There a short flop chain synchronizes it, and a change detector marks the cycle in which the frozen total is copied into the destination result register.

No multi-bit value is synchronized. The held total does not change until the following group completes, and a group lasts many times longer than the synchronizer delay, so the copy always sees a settled word. The processing logic takes each result by pulsing an acknowledge. A result that lands before the previous one was taken overwrites it and raises an overrun flag.

Top module: `quad_intdump_xfer`

## Requirements
- R1: After the destination reset, every result valid and overrun flag is 0 and every result sum is 0.
- R2: Each reported sum equals the two's-complement sum of exactly GROUP_LEN consecutive accepted samples of that channel. Samples are signed, SAMPLE_W bits wide, and are packed with channel c at bits [c*SAMPLE_W +: SAMPLE_W] of the sample bus. A sample is accepted when its valid bit is 1 on a rising edge of the channel clock.
- R3: The result is SUM_W = SAMPLE_W + clog2(GROUP_LEN) bits wide, signed, at bits [c*SUM_W +: SUM_W]. A full group of the most negative or the most positive sample values is reported exactly.
- R4: The accumulator restarts in the same cycle as the group total is frozen. On a continuous stream, consecutive results therefore cover adjacent groups with no sample dropped or counted twice.
- R5: A channel's result valid rises when a new total is captured and stays high until that channel's acknowledge is seen high on a destination clock edge. It then falls in the next cycle, unless a new capture happens in that same cycle.
- R6: If a new total is captured while the previous one is still unacknowledged, the overrun flag rises, the result is replaced by the newer total, and valid stays high. The overrun flag clears together with valid on acknowledge.
- R7: Channels are independent. Each one runs on its own clock and produces its own sums, and traffic on one channel does not alter another channel's result.
- R8: A channel's result sum changes only in a cycle where a new total is captured. Otherwise it holds its value.
- R9: A sample presented with its valid bit at 0 is not added and does not advance the group count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | NUM_CH | Per-channel capture clock |
| src_rst_n | input | NUM_CH | Per-channel active-low asynchronous reset |
| smp_data | input | NUM_CH*SAMPLE_W | Packed signed samples, one field per channel |
| smp_vld | input | NUM_CH | Per-channel sample valid |
| dst_clk | input | 1 | Common processing clock |
| dst_rst_n | input | 1 | Active-low asynchronous reset of the processing domain |
| res_ack | input | NUM_CH | Per-channel acknowledge of the current result |
| res_sum | output | NUM_CH*SUM_W | Packed signed group totals |
| res_vld | output | NUM_CH | Per-channel unacknowledged-result flag |
| res_ovr | output | NUM_CH | Per-channel overrun flag |

## Verification
The summation is driven with a signed ramp that has invalid cycles carrying junk values inserted into it. This pattern separates correct gating by valid from counting every clock cycle. Groups made entirely of the extreme negative or extreme positive value expose any shortage of accumulator width or any slip in sign extension. A continuous two-group stream on one channel shows whether the restart at a group boundary loses or repeats a sample. A deliberately unacknowledged result followed by a second group distinguishes the overwrite-and-flag path from a simple hold. Finally, all four channels run at once with unrelated clocks and patterns to reveal any cross-channel mixing.

// File: rtl/qid_pkg.sv
package qid_pkg;
    localparam int SYNC_DEPTH_DEF = 3;

    function automatic int sum_width(input int smp_w, input int group_len);
        return smp_w + $clog2(group_len);
    endfunction
endpackage

// File: rtl/qid_sync.sv
module qid_sync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/qid_src_integ.sv
module qid_src_integ #(
    parameter int SAMPLE_W  = 12,
    parameter int GROUP_LEN = 16,
    parameter int SUM_W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] smp_i,
    input  logic                vld_i,
    output logic [SUM_W-1:0]    hold_o,
    output logic                tgl_o
);
    localparam int CNT_W = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(GROUP_LEN - 1);

    typedef struct packed {
        logic [SUM_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        logic [SUM_W-1:0] hold;
        logic             tgl;
    } integ_t;

    integ_t st_d, st_q;
    logic [SUM_W-1:0] smp_ext;

    always_comb begin
        smp_ext = {{(SUM_W-SAMPLE_W){smp_i[SAMPLE_W-1]}}, smp_i};
        st_d = st_q;
        if (vld_i) begin
            if (st_q.cnt == LAST_IDX) begin
                st_d.hold = st_q.acc + smp_ext;
                st_d.acc  = '0;
                st_d.cnt  = '0;
                st_d.tgl  = ~st_q.tgl;
            end else begin
                st_d.acc = st_q.acc + smp_ext;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o = st_q.hold;
    assign tgl_o  = st_q.tgl;
endmodule

// File: rtl/qid_dst_capture.sv
module qid_dst_capture #(
    parameter int SUM_W       = 16,
    parameter int SYNC_STAGES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tgl_i,
    input  logic [SUM_W-1:0] hold_i,
    input  logic             ack_i,
    output logic [SUM_W-1:0] sum_o,
    output logic             vld_o,
    output logic             ovr_o
);
    typedef struct packed {
        logic             prev;
        logic             vld;
        logic             ovr;
        logic [SUM_W-1:0] sum;
    } cap_t;

    cap_t st_d, st_q;
    logic tgl_s;
    logic stb_edge;

    qid_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (tgl_i),
        .q_o   (tgl_s)
    );

    always_comb begin
        st_d      = st_q;
        stb_edge  = tgl_s ^ st_q.prev;
        st_d.prev = tgl_s;
        if (stb_edge) begin
            st_d.sum = hold_i;
            st_d.vld = 1'b1;
            st_d.ovr = (st_q.vld | st_q.ovr) & ~ack_i;
        end else begin
            st_d.vld = st_q.vld & ~ack_i;
            st_d.ovr = st_q.ovr & ~ack_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_o = st_q.sum;
    assign vld_o = st_q.vld;
    assign ovr_o = st_q.ovr;
endmodule

// File: rtl/quad_intdump_xfer.sv
module quad_intdump_xfer #(
    parameter int NUM_CH      = 4,
    parameter int SAMPLE_W    = 12,
    parameter int GROUP_LEN   = 16,
    parameter int SYNC_STAGES = qid_pkg::SYNC_DEPTH_DEF,
    localparam int SUM_W      = qid_pkg::sum_width(SAMPLE_W, GROUP_LEN)
) (
    input  logic [NUM_CH-1:0]          src_clk,
    input  logic [NUM_CH-1:0]          src_rst_n,
    input  logic [NUM_CH*SAMPLE_W-1:0] smp_data,
    input  logic [NUM_CH-1:0]          smp_vld,
    input  logic                       dst_clk,
    input  logic                       dst_rst_n,
    input  logic [NUM_CH-1:0]          res_ack,
    output logic [NUM_CH*SUM_W-1:0]    res_sum,
    output logic [NUM_CH-1:0]          res_vld,
    output logic [NUM_CH-1:0]          res_ovr
);
    logic [SUM_W-1:0]  hold_w [NUM_CH];
    logic [NUM_CH-1:0] tgl_w;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        qid_src_integ #(
            .SAMPLE_W  (SAMPLE_W),
            .GROUP_LEN (GROUP_LEN),
            .SUM_W     (SUM_W)
        ) u_integ (
            .clk    (src_clk[c]),
            .rst_n  (src_rst_n[c]),
            .smp_i  (smp_data[c*SAMPLE_W +: SAMPLE_W]),
            .vld_i  (smp_vld[c]),
            .hold_o (hold_w[c]),
            .tgl_o  (tgl_w[c])
        );

        qid_dst_capture #(
            .SUM_W       (SUM_W),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_cap (
            .clk    (dst_clk),
            .rst_n  (dst_rst_n),
            .tgl_i  (tgl_w[c]),
            .hold_i (hold_w[c]),
            .ack_i  (res_ack[c]),
            .sum_o  (res_sum[c*SUM_W +: SUM_W]),
            .vld_o  (res_vld[c]),
            .ovr_o  (res_ovr[c])
        );
    end
endmodule

// File: rtl/qid_checker.sv
module qid_checker #(
    parameter int NUM_CH = 4,
    parameter int SUM_W  = 16
) (
    input logic                    dst_clk,
    input logic                    dst_rst_n,
    input logic [NUM_CH-1:0]       res_ack,
    input logic [NUM_CH*SUM_W-1:0] res_sum,
    input logic [NUM_CH-1:0]       res_vld,
    input logic [NUM_CH-1:0]       res_ovr
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_hold_until_ack_R5: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
            (res_vld[i] && !res_ack[i]) |=> res_vld[i]);

        assert_fall_needs_ack_R5: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
            $fell(res_vld[i]) |-> $past(res_ack[i]));

        assert_ovr_with_vld_R6: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
            res_ovr[i] |-> res_vld[i]);

        assert_ovr_needs_pending_R6: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
            $rose(res_ovr[i]) |-> $past(res_vld[i]));

        assert_sum_moves_on_capture_R8: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
            !$stable(res_sum[i*SUM_W +: SUM_W]) |-> res_vld[i]);
    end
endmodule

bind quad_intdump_xfer qid_checker #(.NUM_CH(NUM_CH), .SUM_W(SUM_W)) u_qid_checker (
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .res_ack   (res_ack),
    .res_sum   (res_sum),
    .res_vld   (res_vld),
    .res_ovr   (res_ovr)
);

// File: tb/tb_quad_intdump_xfer.sv
`timescale 1ns/1ps
module tb_quad_intdump_xfer;
    localparam int NUM_CH    = 4;
    localparam int SAMPLE_W  = 12;
    localparam int GROUP_LEN = 16;
    localparam int SUM_W     = SAMPLE_W + $clog2(GROUP_LEN);

    logic sc0 = 0, sc1 = 0, sc2 = 0, sc3 = 0;
    logic dst_clk = 0;
    logic [NUM_CH-1:0] src_clk;
    logic [NUM_CH-1:0] src_rst_n = '0;
    logic dst_rst_n = 0;
    logic [SAMPLE_W-1:0] smp [NUM_CH];
    logic [NUM_CH*SAMPLE_W-1:0] smp_data;
    logic [NUM_CH-1:0] smp_vld = '0;
    logic [NUM_CH-1:0] res_ack = '0;
    logic [NUM_CH*SUM_W-1:0] res_sum;
    logic [NUM_CH-1:0] res_vld, res_ovr;
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    assign src_clk = {sc3, sc2, sc1, sc0};
    always #2   dst_clk = ~dst_clk;
    always #3   sc0 = ~sc0;
    always #3.5 sc1 = ~sc1;
    always #4.5 sc2 = ~sc2;
    always #5.5 sc3 = ~sc3;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) smp_data[c*SAMPLE_W +: SAMPLE_W] = smp[c];
    end

    quad_intdump_xfer #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .GROUP_LEN(GROUP_LEN)) dut (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .smp_data(smp_data), .smp_vld(smp_vld),
        .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .res_ack(res_ack),
        .res_sum(res_sum), .res_vld(res_vld), .res_ovr(res_ovr));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sum_of(input int ch);
        return int'($signed(res_sum[ch*SUM_W +: SUM_W]));
    endfunction

    task automatic wait_src(input int ch);
        case (ch)
            0: @(negedge sc0);
            1: @(negedge sc1);
            2: @(negedge sc2);
            default: @(negedge sc3);
        endcase
    endtask

    task automatic wait_dst(input int n);
        for (int k = 0; k < n; k++) @(negedge dst_clk);
    endtask

    // Drives one group; junk samples with valid low are inserted when gaps is set (R9).
    task automatic feed_group(input int ch, input int first, input int step,
                              input bit gaps, output int exp);
        exp = 0;
        for (int k = 0; k < GROUP_LEN; k++) begin
            if (gaps && (k % 3 == 1)) begin
                wait_src(ch);
                smp[ch] = 12'h5A5;
                smp_vld[ch] = 1'b0;
            end
            wait_src(ch);
            smp[ch] = SAMPLE_W'(first + k * step);
            smp_vld[ch] = 1'b1;
            exp += first + k * step;
        end
        wait_src(ch);
        smp_vld[ch] = 1'b0;
    endtask

    task automatic wait_result(input int ch, input string req, output bit got);
        got = 0;
        for (int k = 0; k < 2000 && !got; k++) begin
            @(negedge dst_clk);
            got = res_vld[ch];
        end
        check(got, req, int'(got), 1);
    endtask

    task automatic ack_ch(input int ch);
        @(negedge dst_clk);
        res_ack[ch] = 1'b1;
        @(negedge dst_clk);
        res_ack[ch] = 1'b0;
    endtask

    task automatic test_reset();
        check(res_vld == '0, "R1", int'(res_vld), 0);
        check(res_ovr == '0, "R1", int'(res_ovr), 0);
        check(res_sum == '0, "R1", int'(res_sum != '0), 0);
    endtask

    task automatic test_ramp_gaps();
        int exp, held; bit got;
        feed_group(0, -500, 61, 1'b1, exp);
        wait_result(0, "R5", got);
        check(sum_of(0) == exp, "R2", sum_of(0), exp);
        held = sum_of(0);
        wait_dst(12);
        check(res_vld[0] == 1'b1, "R5", int'(res_vld[0]), 1);
        check(sum_of(0) == held, "R8", sum_of(0), held);
        check(sum_of(0) == exp, "R9", sum_of(0), exp);
        ack_ch(0);
        check(res_vld[0] == 1'b0, "R5", int'(res_vld[0]), 0);
        wait_dst(30);
        check(res_vld[0] == 1'b0, "R9", int'(res_vld[0]), 0);
    endtask

    task automatic test_extremes();
        int exp; bit got;
        feed_group(1, -2048, 0, 1'b0, exp);
        wait_result(1, "R3", got);
        check(sum_of(1) == -32768, "R3", sum_of(1), -32768);
        ack_ch(1);
        feed_group(1, 2047, 0, 1'b0, exp);
        wait_result(1, "R3", got);
        check(sum_of(1) == 32752, "R3", sum_of(1), 32752);
        ack_ch(1);
    endtask

    task automatic test_back_to_back();
        int e1, e2; bit got;
        fork
            begin
                feed_group(2, 0, 1, 1'b0, e1);
                feed_group(2, 100, 7, 1'b0, e2);
            end
            begin
                wait_result(2, "R4", got);
                check(sum_of(2) == 120, "R4", sum_of(2), 120);
                ack_ch(2);
                wait_result(2, "R4", got);
                check(sum_of(2) == 2440, "R4", sum_of(2), 2440);
                check(res_ovr[2] == 1'b0, "R4", int'(res_ovr[2]), 0);
                ack_ch(2);
            end
        join
    endtask

    task automatic test_overrun();
        int ea, eb; bit got;
        feed_group(3, 10, 3, 1'b0, ea);
        wait_result(3, "R6", got);
        check(res_ovr[3] == 1'b0, "R6", int'(res_ovr[3]), 0);
        feed_group(3, -900, 40, 1'b1, eb);
        wait_dst(20);
        check(res_ovr[3] == 1'b1, "R6", int'(res_ovr[3]), 1);
        check(res_vld[3] == 1'b1, "R6", int'(res_vld[3]), 1);
        check(sum_of(3) == eb, "R6", sum_of(3), eb);
        ack_ch(3);
        check(res_vld[3] == 1'b0, "R6", int'(res_vld[3]), 0);
        check(res_ovr[3] == 1'b0, "R6", int'(res_ovr[3]), 0);
    endtask

    task automatic test_parallel();
        int e0, e1, e2, e3; bit g0, g1, g2, g3;
        fork
            feed_group(0, 7, 0, 1'b0, e0);
            feed_group(1, 2000, -250, 1'b1, e1);
            feed_group(2, -1, -100, 1'b0, e2);
            feed_group(3, 300, 0, 1'b1, e3);
        join
        wait_result(0, "R7", g0);
        wait_result(1, "R7", g1);
        wait_result(2, "R7", g2);
        wait_result(3, "R7", g3);
        wait_dst(20);
        check(sum_of(0) == e0, "R7", sum_of(0), e0);
        check(sum_of(1) == e1, "R7", sum_of(1), e1);
        check(sum_of(2) == e2, "R7", sum_of(2), e2);
        check(sum_of(3) == e3, "R7", sum_of(3), e3);
        check(res_ovr == '0, "R7", int'(res_ovr), 0);
        for (int c = 0; c < NUM_CH; c++) ack_ch(c);
    endtask

    initial begin
        for (int c = 0; c < NUM_CH; c++) smp[c] = '0;
        wait_dst(10);
        dst_rst_n = 1'b1;
        src_rst_n = '1;
        wait_dst(2);
        test_reset();
        test_ramp_gaps();
        test_extremes();
        test_back_to_back();
        test_overrun();
        test_parallel();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule